// File: doc/BRIEF.md
# Multi-Mode Viterbi Branch Metric Generator

This block produces the branch metrics for a 64-state Viterbi decoder that is shared between two convolutional decoding modes and an intersymbol-interference detection mode. Every metric is an L1 distance, a sum of absolute differences between received soft samples and expected values. In the rate-1/4 mode it scores four 4-bit soft samples against all sixteen possible 4-bit codewords. In the rate-1/2 mode two lanes are forced to erasure and only four codeword metrics are produced. In the detection mode one 5-bit sample is compared against a loadable table of expected samples, one entry per valid transition of a run-length-constrained trellis.

Software or a sequencer fills the expected-sample table through a small write port before detection starts. An upstream unit supplies soft samples with per-lane erasure flags and a one-cycle valid strobe. The metric vector is registered and appears one clock later with its own valid strobe, ready for the add-compare-select array.

Top module: `multimode_bm_gen`

## Requirements
- R1: With mode[1]=0 and mode[0]=0 (rate 1/4), entry c (0..15) of the metric vector equals the sum over lanes k=0..3 of |convIn[4k+3:4k] − E|, where E=15 when bit k of c is 0 and E=0 when bit k of c is 1; entries 16..25 are zero.
- R2: With mode[1]=0 and mode[0]=1 (rate 1/2), lanes 2 and 3 are treated as erased whatever their values and flags, entries 0..3 follow the R1 formula over lanes 0 and 1, and entries 4..25 are zero.
- R3: A lane whose eraseIn bit is 1 adds zero to every metric. In detection mode, eraseIn[0]=1 makes all 26 entries zero.
- R4: With mode[1]=1 (detection mode, mode[0] ignored), entry t (0..25) equals |isiIn − table[t]|, and the convolutional lanes have no effect.
- R5: A cycle with cfgWe=1 and cfgAddr below 26 writes table[cfgAddr]. The stored value is cfgData, clipped to 31 when cfgData exceeds 31. The new value is used for samples strobed in later cycles.
- R6: A write to cfgAddr 26..31 changes no table entry.
- R7: bmValid is high exactly one cycle after a cycle with inValid high. The metric vector updates only at that edge and holds its value otherwise.
- R8: After reset bmValid is 0, every metric entry is 0 and every table entry is 0.
- R9: Entry e of the metric vector occupies bits [6e+5:6e] of bmOut, and each metric is 6 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Sample strobe |
| mode | input | 2 | 00 rate 1/4, 01 rate 1/2, 1x detection |
| convIn | input | 16 | Four 4-bit offset-binary soft samples, lane k at bits [4k+3:4k] |
| isiIn | input | 5 | Detection-mode sample |
| eraseIn | input | 4 | Per-lane erasure flags |
| cfgWe | input | 1 | Table write strobe |
| cfgAddr | input | 5 | Table transition address |
| cfgData | input | 8 | Table write data |
| bmValid | output | 1 | Metric vector valid |
| bmOut | output | 156 | 26 metrics of 6 bits each |

## Verification
Any fault in the registered metric vector is visible on bmOut in the cycle that bmValid rises, so a wrong codeword mapping, a lane left unerased or a wrong table entry shows as a mismatch one clock after the offending strobe. A corrupted table entry does not show until the next detection-mode sample, so every table write is followed by a detection-mode readout of all 26 entries. The same readout catches writes to ignored addresses. Hold behaviour is observed by changing the inputs with the strobe low and comparing the metric vector against its previous value.

// File: rtl/bmg_pkg.sv
package bmg_pkg;
  // number of soft lanes in the widest convolutional mode
  localparam int CODE_LANES = 4;
  // lanes kept live in the punctured mode
  localparam int HALF_LANES = 2;

  typedef struct packed {
    logic load;      // capture a new metric vector
    logic isIsi;     // detection mode selected
    logic halfRate;  // punctured convolutional mode
    logic tblWrite;  // legal table write this cycle
  } bmgStrobe_t;
endpackage

// File: rtl/bmg_ctrl.sv
module bmg_ctrl
  import bmg_pkg::*;
#(
  parameter int NUM_TRANS = 26,
  parameter int ADDR_W    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        mode,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  output bmgStrobe_t        strb,
  output logic              bmValid
);

  always_comb begin
    strb.load     = inValid;
    strb.isIsi    = mode[1];
    strb.halfRate = !mode[1] && mode[0];
    strb.tblWrite = cfgWe && ({1'b0, cfgAddr} < (ADDR_W+1)'(NUM_TRANS));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bmValid <= 1'b0;
    else       bmValid <= inValid;
  end

  // R7
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> bmValid);

  // R7
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !bmValid);

endmodule

// File: rtl/bmg_datapath.sv
module bmg_datapath
  import bmg_pkg::*;
#(
  parameter int SOFT_W    = 4,
  parameter int ISI_W     = 5,
  parameter int NUM_TRANS = 26,
  parameter int ADDR_W    = 5,
  parameter int CFG_W     = 8,
  parameter int NUM_ENT   = 26,
  parameter int METRIC_W  = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  bmgStrobe_t                    strb,
  input  logic [CODE_LANES*SOFT_W-1:0]  convIn,
  input  logic [ISI_W-1:0]              isiIn,
  input  logic [CODE_LANES-1:0]         eraseIn,
  input  logic [ADDR_W-1:0]             cfgAddr,
  input  logic [CFG_W-1:0]              cfgData,
  output logic [NUM_ENT*METRIC_W-1:0]   bmOut
);

  localparam int NUM_CODE  = 1 << CODE_LANES;
  localparam int HALF_CODE = 1 << HALF_LANES;
  localparam logic [SOFT_W-1:0] SOFT_TOP = '1;
  localparam logic [ISI_W-1:0]  ISI_TOP  = '1;
  localparam logic [CODE_LANES-1:0] HALF_MASK =
    {{(CODE_LANES-HALF_LANES){1'b1}}, {HALF_LANES{1'b0}}};

  function automatic logic [SOFT_W-1:0] softDist(input logic [SOFT_W-1:0] a,
                                                 input logic [SOFT_W-1:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  function automatic logic [ISI_W-1:0] isiDist(input logic [ISI_W-1:0] a,
                                               input logic [ISI_W-1:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  // expected-sample table for the constrained transitions
  logic [ISI_W-1:0] tbl [NUM_TRANS];
  logic [ISI_W-1:0] wrVal;

  always_comb wrVal = (cfgData > CFG_W'(ISI_TOP)) ? ISI_TOP : cfgData[ISI_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int t = 0; t < NUM_TRANS; t++) tbl[t] <= '0;
    end else if (strb.tblWrite) begin
      for (int t = 0; t < NUM_TRANS; t++)
        if (cfgAddr == ADDR_W'(t)) tbl[t] <= wrVal;
    end
  end

  // lanes that contribute nothing this cycle
  logic [CODE_LANES-1:0] laneOff;
  always_comb laneOff = eraseIn | (strb.halfRate ? HALF_MASK : '0);

  logic [NUM_ENT*METRIC_W-1:0] nextBm;

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    logic [METRIC_W-1:0] convM;
    logic [METRIC_W-1:0] isiM;

    if (e < NUM_CODE) begin : g_conv
      always_comb begin
        convM = '0;
        if (!(strb.halfRate && (e >= HALF_CODE))) begin
          for (int k = 0; k < CODE_LANES; k++) begin
            if (!laneOff[k])
              convM = convM + METRIC_W'(softDist(convIn[k*SOFT_W +: SOFT_W],
                                ((((e >> k) & 1) != 0) ? '0 : SOFT_TOP)));
          end
        end
      end
    end else begin : g_noconv
      assign convM = '0;
    end

    if (e < NUM_TRANS) begin : g_isi
      assign isiM = eraseIn[0] ? '0 : METRIC_W'(isiDist(isiIn, tbl[e]));
      // R6
      tbl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        !strb.tblWrite |=> $stable(tbl[e]));
    end else begin : g_noisi
      assign isiM = '0;
    end

    assign nextBm[e*METRIC_W +: METRIC_W] = strb.isIsi ? isiM : convM;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          bmOut <= '0;
    else if (strb.load) bmOut <= nextBm;
  end

  // R2
  half_tail_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.halfRate) |=>
      (bmOut[NUM_ENT*METRIC_W-1 : HALF_CODE*METRIC_W] == '0));

  // R1
  conv_tail_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !strb.isIsi) |=>
      (bmOut[NUM_ENT*METRIC_W-1 : NUM_CODE*METRIC_W] == '0));

  // R7
  metric_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(bmOut));

endmodule

// File: rtl/multimode_bm_gen.sv
module multimode_bm_gen
  import bmg_pkg::*;
#(
  parameter  int SOFT_W    = 4,
  parameter  int ISI_W     = 5,
  parameter  int NUM_TRANS = 26,
  parameter  int ADDR_W    = 5,
  parameter  int CFG_W     = 8,
  localparam int NUM_CODE  = 1 << CODE_LANES,
  localparam int NUM_ENT   = (NUM_CODE > NUM_TRANS) ? NUM_CODE : NUM_TRANS,
  localparam int CONV_MAX  = CODE_LANES * ((1 << SOFT_W) - 1),
  localparam int ISI_MAX   = (1 << ISI_W) - 1,
  localparam int METRIC_W  = $clog2(((CONV_MAX > ISI_MAX) ? CONV_MAX : ISI_MAX) + 1)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          inValid,
  input  logic [1:0]                    mode,
  input  logic [CODE_LANES*SOFT_W-1:0]  convIn,
  input  logic [ISI_W-1:0]              isiIn,
  input  logic [CODE_LANES-1:0]         eraseIn,
  input  logic                          cfgWe,
  input  logic [ADDR_W-1:0]             cfgAddr,
  input  logic [CFG_W-1:0]              cfgData,
  output logic                          bmValid,
  output logic [NUM_ENT*METRIC_W-1:0]   bmOut
);

  bmgStrobe_t strb;

  bmg_ctrl #(
    .NUM_TRANS (NUM_TRANS),
    .ADDR_W    (ADDR_W)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .mode    (mode),
    .cfgWe   (cfgWe),
    .cfgAddr (cfgAddr),
    .strb    (strb),
    .bmValid (bmValid)
  );

  bmg_datapath #(
    .SOFT_W    (SOFT_W),
    .ISI_W     (ISI_W),
    .NUM_TRANS (NUM_TRANS),
    .ADDR_W    (ADDR_W),
    .CFG_W     (CFG_W),
    .NUM_ENT   (NUM_ENT),
    .METRIC_W  (METRIC_W)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .convIn  (convIn),
    .isiIn   (isiIn),
    .eraseIn (eraseIn),
    .cfgAddr (cfgAddr),
    .cfgData (cfgData),
    .bmOut   (bmOut)
  );

endmodule

// File: tb/test_multimode_bm_gen.sv
`timescale 1ns/1ps
module test_multimode_bm_gen;

  localparam int NE = 26;
  localparam int MW = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [15:0] convIn = '0;
  logic [4:0] isiIn = '0;
  logic [3:0] eraseIn = '0;
  logic cfgWe = 1'b0;
  logic [4:0] cfgAddr = '0;
  logic [7:0] cfgData = '0;
  logic bmValid;
  logic [NE*MW-1:0] bmOut;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;
  int tblM [NE];

  always #2.5 clk = ~clk;

  multimode_bm_gen i_multimode_bm_gen (
    .clk(clk), .rstN(rstN), .inValid(inValid), .mode(mode), .convIn(convIn),
    .isiIn(isiIn), .eraseIn(eraseIn), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .bmValid(bmValid), .bmOut(bmOut)
  );

  function automatic int absI(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic logic [NE*MW-1:0] model(input logic [1:0] md,
      input logic [15:0] cv, input logic [4:0] iv, input logic [3:0] er);
    logic [NE*MW-1:0] vec;
    int m, ncw, ex;
    vec = '0;
    for (int i = 0; i < NE; i++) begin
      m = 0;
      if (md[1]) begin
        if (!er[0]) m = absI(int'(iv) - tblM[i]);
      end else begin
        ncw = md[0] ? 4 : 16;
        if (i < ncw) begin
          for (int k = 0; k < 4; k++) begin
            if (!(er[k] || (md[0] && k >= 2))) begin
              ex = (((i >> k) & 1) != 0) ? 0 : 15;
              m = m + absI(int'(cv[k*4 +: 4]) - ex);
            end
          end
        end
      end
      vec[i*MW +: MW] = MW'(m);
    end
    return vec;
  endfunction

  task automatic checkVec(input string req, input logic [NE*MW-1:0] exp);
    nChecks++;
    if (bmOut !== exp) begin
      nFails++;
      $display("FAIL %s bmOut actual=%h expected=%h", req, bmOut, exp);
    end
  endtask

  task automatic checkBit(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s bmValid actual=%b expected=%b", req, act, exp);
    end
  endtask

  // strobe one sample and check the vector one cycle later
  task automatic sample(input string req, input logic [1:0] md,
      input logic [15:0] cv, input logic [4:0] iv, input logic [3:0] er);
    @(negedge clk);
    mode = md; convIn = cv; isiIn = iv; eraseIn = er; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    checkBit(req, bmValid, 1'b1);
    checkVec(req, model(md, cv, iv, er));
  endtask

  task automatic cfgWrite(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
    if (a < 5'd26) tblM[a] = (d > 8'd31) ? 31 : int'(d);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [NE*MW-1:0] held;
    void'($urandom(32'd1234));
    for (int i = 0; i < NE; i++) tblM[i] = 0;
    repeat (3) @(negedge clk);
    // R8 reset state
    checkBit("R8", bmValid, 1'b0);
    checkVec("R8", '0);
    rstN = 1'b1;
    @(negedge clk);
    // R8 table cleared: detection metric equals the sample itself
    sample("R8 R4", 2'b10, 16'h0, 5'd19, 4'h0);

    // R1 R9 directed corners
    sample("R1 R9", 2'b00, 16'hFFFF, 5'd0, 4'h0);
    sample("R1", 2'b00, 16'h0000, 5'd0, 4'h0);
    sample("R1", 2'b00, 16'h7C83, 5'd0, 4'h0);
    // R3 all lanes erased
    sample("R3", 2'b00, 16'h5A3C, 5'd0, 4'hF);
    sample("R3", 2'b00, 16'h5A3C, 5'd0, 4'h5);
    // R2 upper lanes ignored even with their flags clear
    sample("R2", 2'b01, 16'hFF00, 5'd0, 4'h0);
    sample("R2", 2'b01, 16'h00F3, 5'd0, 4'h2);

    for (int n = 0; n < 40; n++)
      sample("R1", 2'b00, 16'($urandom), 5'($urandom), 4'($urandom) & 4'h3);
    for (int n = 0; n < 30; n++)
      sample("R2", 2'b01, 16'($urandom), 5'($urandom), 4'($urandom));
    for (int n = 0; n < 20; n++)
      sample("R3", 2'b00, 16'($urandom), 5'd0, 4'($urandom));

    // R5 table load, including clipped values
    for (int t = 0; t < NE; t++) cfgWrite(5'(t), 8'($urandom));
    cfgWrite(5'd3, 8'hC7);
    cfgWrite(5'd25, 8'd31);
    cfgWrite(5'd0, 8'd0);
    sample("R5", 2'b10, 16'h0, 5'd16, 4'h0);
    // R6 writes to ignored addresses
    for (int a = 26; a < 32; a++) cfgWrite(5'(a), 8'(a + 1));
    sample("R6", 2'b10, 16'h0, 5'd16, 4'h0);
    sample("R6", 2'b11, 16'hABCD, 5'd31, 4'h0);
    // R3 erased detection sample
    sample("R3", 2'b10, 16'h0, 5'd9, 4'h1);
    for (int n = 0; n < 30; n++)
      sample("R4", {1'b1, 1'($urandom)}, 16'($urandom), 5'($urandom), 4'($urandom) & 4'hE);

    // R7 hold with strobe low
    sample("R7", 2'b00, 16'h1234, 5'd0, 4'h0);
    held = bmOut;
    @(negedge clk);
    mode = 2'b10; convIn = 16'hFFFF; isiIn = 5'd31; eraseIn = 4'h0;
    checkBit("R7", bmValid, 1'b0);
    @(negedge clk);
    checkBit("R7", bmValid, 1'b0);
    checkVec("R7", held);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule